// File: doc/BRIEF.md
# Compact 16-bit Multicycle Processor Core

This core runs a 17-instruction, 16-bit instruction set from a byte-addressed memory that stores 16-bit words with the low byte at the lower address. It has eight 16-bit registers. Register 0 is the program counter, so any instruction may read it as an operand or write it as a destination. Each instruction passes through fetch, decode and execute states. A load adds one write-back state. The core has one synchronous memory port, which the surrounding system provides. A read returns its data on the clock edge after the request.

Register-relative jumps and branches add twice a register's value to the address of the jump or branch itself. Loads and stores add a sign-extended 5-bit word offset, scaled by two, to a base register. The halt instruction and every unassigned opcode stop the core. The core then raises `halted` and keeps all of its state until the next reset. The trap-related registers r5 to r7 act as plain storage.

Top module: `cpu16_core`

## Requirements
- R1: After reset every register reads zero and the first fetch reads byte address 0 with `halted` low. The asynchronous active-low reset is released after two clock edges.
- R2: An instruction takes three cycles (fetch, decode, execute) and a load takes four. The fetch cycle drives `mem_rd` with `mem_addr` equal to the PC. `mem_rd` and `mem_we` are never high together. The cycle after a store is the fetch of the next instruction.
- R3: A store writes bits 7:0 to the even byte address and bits 15:8 to the next byte. A load assembles the word in the same order.
- R4: Load (opcode 0x01) and store (0x02) use the address base + sext(imm5)×2. The fields are dest/src in bits 10:8, base in bits 7:5 and imm5 in bits 4:0.
- R5: lui (0x03) writes imm8 (bits 7:0) into bits 15:8 of the destination and zero into the low byte.
- R6: addi (0x04) adds a sign-extended imm5. add 0x05, sub 0x06, and 0x07, or 0x09 and xor 0x0A combine src1 (bits 7:5) with src2 (bits 4:2). not 0x08 inverts src1. Results wrap at 16 bits.
- R7: sll 0x0B, srl 0x0C and sra 0x0D shift src1 by the low 4 bits of src2. sra copies the sign bit into the vacated bits.
- R8: Reading r0 as an operand gives the address of the current instruction. An ALU or load result written to r0 becomes the next fetch address and replaces the +2 step.
- R9: jr (0x0E) sets the PC to the instruction's own address plus twice the register in bits 10:8.
- R10: beq (0x0F) and bne (0x10) compare src1 with src2. When the condition holds, the PC becomes the instruction address plus twice the register in bits 10:8. Otherwise the PC advances by 2.
- R11: halt (0x1F) and any unassigned opcode raise `halted`. The core then issues no further memory access and freezes all of its state until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read request; data returns on the next edge |
| mem_we | output | 1 | Write request for one word |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| halted | output | 1 | Core stopped |

## Verification
Any wrong internal state shows up on the memory port within one instruction. A corrupted PC shows in the next fetch address. A wrong state sequence changes the cycle in which `mem_rd` or `mem_we` rises. A wrong register value appears as a wrong store address or store data once a later instruction uses it. The bench therefore compares every bus output on every cycle against a cycle-level model. Register values that never reach a store are still caught by the final memory image, because the program stores every intermediate result.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [4:0] {
    OP_LW   = 5'h01,
    OP_SW   = 5'h02,
    OP_LUI  = 5'h03,
    OP_ADDI = 5'h04,
    OP_ADD  = 5'h05,
    OP_SUB  = 5'h06,
    OP_AND  = 5'h07,
    OP_NOT  = 5'h08,
    OP_OR   = 5'h09,
    OP_XOR  = 5'h0A,
    OP_SLL  = 5'h0B,
    OP_SRL  = 5'h0C,
    OP_SRA  = 5'h0D,
    OP_JR   = 5'h0E,
    OP_BEQ  = 5'h0F,
    OP_BNE  = 5'h10,
    OP_HALT = 5'h1F
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOT,
    ALU_SLL,
    ALU_SRL,
    ALU_SRA,
    ALU_PASSB
  } alu_op_e;

endpackage

// File: rtl/cpu16_rst_sync.sv
module cpu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOT: y = ~a;
      ALU_SLL: y = a << shamt;
      ALU_SRL: y = a >> shamt;
      ALU_SRA: y = $signed(a) >>> shamt;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_next,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  input  logic [AW-1:0]     ra_c,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_c,
  output logic [DATA_W-1:0] pc
);

  logic [DATA_W-1:0] regs_q [NREG];
  logic [NREG-1:0]   wen;
  logic [DATA_W-1:0] wdat [NREG];

  // r0 doubles as the program counter: an explicit write beats the step
  for (genvar k = 0; k < NREG; k++) begin : g_wr
    if (k == 0) begin : g_pc
      assign wen[k]  = pc_we | (we && (waddr == AW'(k)));
      assign wdat[k] = (we && (waddr == AW'(k))) ? wdata : pc_next;
    end else begin : g_gp
      assign wen[k]  = we && (waddr == AW'(k));
      assign wdat[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
    end else begin
      for (int k = 0; k < NREG; k++)
        if (wen[k]) regs_q[k] <= wdat[k];
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];
  assign rd_c = regs_q[ra_c];
  assign pc   = regs_q[0];

  // R8: a result aimed at r0 is the next PC, whatever the step says
  a_r8_r0_write_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && waddr == '0) |=> pc == $past(wdata));

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_rd,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        halted
);

  localparam int RAW  = $clog2(NREG);
  localparam int IMMW = 5;
  localparam int UIW  = XLEN / 2;

  logic rst_i;
  cpu16_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_no(rst_i));

  state_e            state_q, state_d;
  logic [XLEN-1:0]   ir_q;
  logic              ir_en;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ir_en) ir_q <= mem_rdata;
    end
  end

  // instruction fields
  opcode_e          op;
  logic [RAW-1:0]   f_rd, f_rs1, f_rs2;
  logic [XLEN-1:0]  imm_s;
  logic [UIW-1:0]   imm8;
  assign op    = opcode_e'(ir_q[15:11]);
  assign f_rd  = ir_q[10:8];
  assign f_rs1 = ir_q[7:5];
  assign f_rs2 = ir_q[4:2];
  assign imm_s = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign imm8  = ir_q[UIW-1:0];

  // datapath
  logic            rf_we, pc_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata, pc_next;
  logic [XLEN-1:0] rd_a, rd_b, rd_c, pc;
  logic [XLEN-1:0] alu_b, alu_y, ea, pc_plus2, br_tgt;
  alu_op_e         alu_op;

  cpu16_regfile #(.DATA_W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_ni(rst_i),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .pc_we(pc_we), .pc_next(pc_next),
    .ra_a(f_rs1), .ra_b(f_rs2), .ra_c(f_rd),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .pc(pc)
  );

  cpu16_alu #(.DATA_W(XLEN)) u_alu (.op(alu_op), .a(rd_a), .b(alu_b), .y(alu_y));

  assign ea        = rd_a + (imm_s << 1);
  assign pc_plus2  = pc + XLEN'(2);
  assign br_tgt    = pc + (rd_c << 1);
  assign mem_wdata = rd_c;
  assign halted    = (state_q == ST_HALT);

  always_comb begin
    state_d  = state_q;
    ir_en    = 1'b0;
    mem_rd   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    rf_we    = 1'b0;
    rf_waddr = f_rd;
    rf_wdata = alu_y;
    pc_we    = 1'b0;
    pc_next  = pc_plus2;
    alu_op   = ALU_ADD;
    alu_b    = rd_b;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = pc;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        ir_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        pc_we   = 1'b1;
        case (op)
          OP_LW:   begin mem_rd = 1'b1; mem_addr = ea; state_d = ST_MEM; end
          OP_SW:   begin mem_we = 1'b1; mem_addr = ea; end
          OP_LUI:  begin alu_op = ALU_PASSB; alu_b = {imm8, {UIW{1'b0}}}; rf_we = 1'b1; end
          OP_ADDI: begin alu_b = imm_s; rf_we = 1'b1; end
          OP_ADD:  rf_we = 1'b1;
          OP_SUB:  begin alu_op = ALU_SUB; rf_we = 1'b1; end
          OP_AND:  begin alu_op = ALU_AND; rf_we = 1'b1; end
          OP_NOT:  begin alu_op = ALU_NOT; rf_we = 1'b1; end
          OP_OR:   begin alu_op = ALU_OR;  rf_we = 1'b1; end
          OP_XOR:  begin alu_op = ALU_XOR; rf_we = 1'b1; end
          OP_SLL:  begin alu_op = ALU_SLL; rf_we = 1'b1; end
          OP_SRL:  begin alu_op = ALU_SRL; rf_we = 1'b1; end
          OP_SRA:  begin alu_op = ALU_SRA; rf_we = 1'b1; end
          OP_JR:   pc_next = br_tgt;
          OP_BEQ:  if (rd_a == rd_b) pc_next = br_tgt;
          OP_BNE:  if (rd_a != rd_b) pc_next = br_tgt;
          default: begin pc_we = 1'b0; state_d = ST_HALT; end
        endcase
      end
      ST_MEM: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
        state_d  = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // R11: once stopped, nothing moves
  a_r11_halt_frozen: assert property (@(posedge clk) disable iff (!rst_i)
    halted |=> halted && $stable(pc));

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    halted |-> !mem_rd && !mem_we);

  // R2: one port, one direction per cycle
  a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_i)
    !(mem_rd && mem_we));

  // R2: a store is followed by the fetch of the next sequential word
  a_r2_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_i)
    mem_we |=> mem_rd && (mem_addr == $past(pc) + 16'd2));

endmodule

// File: tb/test_cpu16_core.sv
`timescale 1ns/1ps
module test_cpu16_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_rd, mem_we, halted;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  cpu16_core i_cpu16_core (
    .clk(clk), .rst_n(rst_n),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  // ---------------- memory seen by the design ----------------
  logic [7:0] dm [512];
  logic [8:0] da;
  assign da = mem_addr[8:0];

  always @(posedge clk) begin
    if (mem_we) begin
      dm[da]        <= mem_wdata[7:0];
      dm[da + 9'd1] <= mem_wdata[15:8];
    end
    if (mem_rd) mem_rdata <= {dm[da + 9'd1], dm[da]};
  end

  // ---------------- behavioural reference ----------------
  logic [7:0]  mm [512];
  logic [15:0] mr [8];
  logic [15:0] mir, mea;
  int          mph;
  logic [1:0]  msync;

  function automatic logic [15:0] mrd(input logic [15:0] a);
    return {mm[(a + 16'd1) & 16'h1FF], mm[a & 16'h1FF]};
  endfunction

  function automatic logic [15:0] m_ea(input logic [15:0] ir);
    int simm;
    simm = ir[4] ? int'(ir[4:0]) - 32 : int'(ir[4:0]);
    return 16'(int'(mr[ir[7:5]]) + 2 * simm);
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 8; k++) mr[k] = '0;
    mph = 0;
    mir = '0;
    mea = '0;
  endtask

  task automatic m_exec();
    int op;
    logic [2:0]  d;
    logic [15:0] va, vb, vd, pcv, res, ea;
    int sh;
    op  = int'(mir[15:11]);
    d   = mir[10:8];
    va  = mr[mir[7:5]];
    vb  = mr[mir[4:2]];
    vd  = mr[d];
    pcv = mr[0];
    sh  = int'(vb) % 16;
    ea  = m_ea(mir);
    mph = 0;
    case (op)
      1: begin mea = ea; mr[0] = pcv + 16'd2; mph = 3; end
      2: begin
        mm[ea & 16'h1FF]           = vd[7:0];
        mm[(ea + 16'd1) & 16'h1FF] = vd[15:8];
        mr[0] = pcv + 16'd2;
      end
      3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13: begin
        case (op)
          3:  res = {mir[7:0], 8'h00};
          4:  res = 16'(int'(va) + (mir[4] ? int'(mir[4:0]) - 32 : int'(mir[4:0])));
          5:  res = va + vb;
          6:  res = va - vb;
          7:  res = va & vb;
          8:  res = ~va;
          9:  res = va | vb;
          10: res = va ^ vb;
          11: res = 16'(int'(va) * (2 ** sh));
          12: res = 16'(int'(va) / (2 ** sh));
          default: begin
            res = va;
            for (int s = 0; s < sh; s++) res = {res[15], res[15:1]};
          end
        endcase
        mr[0] = pcv + 16'd2;
        mr[d] = res;
      end
      14: mr[0] = pcv + 16'(2 * int'(vd));
      15: mr[0] = (va == vb) ? pcv + 16'(2 * int'(vd)) : pcv + 16'd2;
      16: mr[0] = (va != vb) ? pcv + 16'(2 * int'(vd)) : pcv + 16'd2;
      default: mph = 4;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msync = 2'b00;
      m_reset();
    end else begin
      if (!msync[1]) m_reset();
      else begin
        case (mph)
          0: begin mir = mrd(mr[0]); mph = 1; end
          1: mph = 2;
          2: m_exec();
          3: begin mr[mir[10:8]] = mrd(mea); mph = 0; end
          default: mph = 4;
        endcase
      end
      msync = {msync[0], 1'b1};
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 timing and every bus value, compared each cycle
  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      logic e_rd, e_we, e_halt;
      logic [15:0] e_addr, e_wd;
      e_rd = 1'b0; e_we = 1'b0; e_addr = '0; e_wd = '0;
      e_halt = (mph == 4);
      if (mph == 0) begin e_rd = 1'b1; e_addr = mr[0]; end
      if (mph == 2 && mir[15:11] == 5'h01) begin e_rd = 1'b1; e_addr = m_ea(mir); end
      if (mph == 2 && mir[15:11] == 5'h02) begin
        e_we = 1'b1; e_addr = m_ea(mir); e_wd = mr[mir[10:8]];
      end
      chk("R2 mem_rd", 16'(mem_rd), 16'(e_rd));
      chk("R2 mem_we", 16'(mem_we), 16'(e_we));
      chk("R11 halted", 16'(halted), 16'(e_halt));
      if (e_rd || e_we) chk("R2 mem_addr", mem_addr, e_addr);
      if (e_we) chk("R3 mem_wdata", mem_wdata, e_wd);
    end
  end

  // ---------------- program building ----------------
  function automatic logic [15:0] f_r(int op, int d, int a, int b);
    return 16'((op << 11) | (d << 8) | (a << 5) | (b << 2));
  endfunction
  function automatic logic [15:0] f_i(int op, int d, int a, int imm);
    return 16'((op << 11) | (d << 8) | (a << 5) | (imm & 31));
  endfunction
  function automatic logic [15:0] f_u(int op, int d, int imm8);
    return 16'((op << 11) | (d << 8) | (imm8 & 255));
  endfunction

  task automatic put_w(input int addr, input logic [15:0] w);
    dm[addr] = w[7:0]; dm[addr + 1] = w[15:8];
    mm[addr] = w[7:0]; mm[addr + 1] = w[15:8];
  endtask
  task automatic put(input int idx, input logic [15:0] w);
    put_w(2 * idx, w);
  endtask
  task automatic clear_mem();
    for (int k = 0; k < 512; k++) begin dm[k] = 8'h00; mm[k] = 8'h00; end
  endtask
  function automatic logic [15:0] dw(input int addr);
    return {dm[addr + 1], dm[addr]};
  endfunction

  task automatic load_prog1();
    clear_mem();
    put(0,  f_u(3, 2, 8'h80));        // lui r2
    put(1,  f_i(4, 3, 0, 5));         // addi r3 = pc + 5
    put(2,  f_r(13, 4, 2, 3));        // sra
    put(3,  f_u(3, 1, 8'h01));        // lui r1 = 0x0100
    put(4,  f_i(2, 4, 1, 0));
    put(5,  f_r(12, 5, 2, 3));        // srl
    put(6,  f_i(2, 5, 1, 1));
    put(7,  f_r(11, 6, 3, 3));        // sll
    put(8,  f_i(2, 6, 1, 2));
    put(9,  f_r(5, 7, 4, 6));  put(10, f_i(2, 7, 1, 3));
    put(11, f_r(6, 7, 3, 2));  put(12, f_i(2, 7, 1, 4));
    put(13, f_r(7, 7, 4, 6));  put(14, f_i(2, 7, 1, 5));
    put(15, f_r(9, 7, 4, 6));  put(16, f_i(2, 7, 1, 6));
    put(17, f_r(10, 7, 4, 6)); put(18, f_i(2, 7, 1, 7));
    put(19, f_r(8, 7, 4, 0));  put(20, f_i(2, 7, 1, 8));
    put(21, f_i(4, 2, 2, -1)); put(22, f_i(2, 2, 1, 9));
    put(23, f_r(6, 7, 7, 7));         // r7 = 0
    put(24, f_i(4, 7, 7, 15));
    put(25, f_i(4, 7, 7, 2));         // r7 = 17
    put(26, f_r(11, 7, 3, 7));        // shift by 17 -> by 1
    put(27, f_i(2, 7, 1, 10));
    put(28, f_i(4, 5, 1, 8));         // r5 = 0x108
    put(29, f_i(1, 4, 5, -4));        // lw from 0x100
    put(30, f_i(4, 4, 4, 1));
    put(31, f_i(2, 4, 1, 11));
    put(32, f_r(6, 6, 6, 6));
    put(33, f_i(4, 6, 6, 2));         // r6 = 2
    put(34, f_r(15, 6, 2, 2));        // beq taken
    put(35, f_i(2, 6, 1, 12));        // skipped
    put(36, f_r(16, 6, 2, 2));        // bne not taken
    put(37, f_i(2, 6, 1, 13));
    put(38, f_r(16, 6, 2, 3));        // bne taken
    put(39, f_i(2, 6, 1, 14));        // skipped
    put(40, f_r(15, 6, 2, 3));        // beq not taken
    put(41, f_u(14, 6, 0));           // jr r6
    put(42, f_i(2, 6, 5, 11));        // skipped
    put(43, f_i(1, 0, 5, 14));        // lw r0 <- 0x124
    put(44, f_i(2, 6, 5, 12));        // skipped
    put(45, 16'hF800);                // halt, skipped
    put(46, f_i(4, 0, 0, 6));         // r0 = 92 + 6
    put(47, f_i(2, 6, 5, 13));        // skipped
    put(48, 16'hF800);                // skipped
    put(49, f_i(2, 0, 5, 15));        // store r0
    put(50, 16'hF800);
    put_w(16'h124, 16'h005C);
  endtask

  task automatic load_prog2();
    clear_mem();
    put(0, f_i(4, 2, 0, 3));          // r2 = 3
    put(1, f_i(2, 2, 1, 15));         // to r1 + 30
    put(2, 16'h8800);                 // unassigned opcode 0x11
    put(3, f_i(2, 2, 1, 14));         // must not run
    put(4, 16'hF800);
  endtask

  task automatic run_to_halt(input string tag);
    int n;
    n = 0;
    while (!halted && n < 4000) begin @(negedge clk); n++; end
    chk(tag, 16'(halted), 16'd1);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    load_prog1();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halted in reset", 16'(halted), 16'd0);
    chk("R1 no store in reset", 16'(mem_we), 16'd0);
    chk("R1 first fetch address", mem_addr, 16'h0000);
    cmp_en = 1'b1;
    rst_n  = 1'b1;
    run_to_halt("R11 halt reached prog1");
    chk("R11 quiet after halt", 16'(mem_rd | mem_we), 16'd0);

    chk("R3 low byte at even address", 16'(dm[16'h100]), 16'h0000);
    chk("R3 high byte at odd address", 16'(dm[16'h101]), 16'h00FF);
    chk("R7 sra",                dw(16'h100), 16'hFF00);
    chk("R7 srl",                dw(16'h102), 16'h0100);
    chk("R8 r0 read as operand", dw(16'h104), 16'h0380);
    chk("R6 add",                dw(16'h106), 16'h0280);
    chk("R6 sub",                dw(16'h108), 16'h8007);
    chk("R6 and",                dw(16'h10A), 16'h0300);
    chk("R6 or",                 dw(16'h10C), 16'hFF80);
    chk("R6 xor",                dw(16'h10E), 16'hFC80);
    chk("R6 not",                dw(16'h110), 16'h00FF);
    chk("R6 addi negative",      dw(16'h112), 16'h7FFF);
    chk("R7 shift amount low 4 bits", dw(16'h114), 16'h000E);
    chk("R4 load negative offset",    dw(16'h116), 16'hFF01);
    chk("R10 beq taken skips",   dw(16'h118), 16'h0000);
    chk("R10 bne not taken",     dw(16'h11A), 16'h0002);
    chk("R10 bne taken skips",   dw(16'h11C), 16'h0000);
    chk("R9 jr skips",           dw(16'h11E), 16'h0000);
    chk("R8 load to r0 skips",   dw(16'h120), 16'h0000);
    chk("R8 addi to r0 skips",   dw(16'h122), 16'h0000);
    chk("R8 r0 after jumps",     dw(16'h126), 16'h0062);
    chk("R5 lui upper byte",     dw(16'h100) & 16'h00FF, 16'h0000);
    for (int a = 16'h100; a < 16'h128; a += 2)
      chk("R4 memory image vs model", dw(a), mrd(16'(a)));

    // second run: registers must restart from zero
    rst_n = 1'b0;
    @(negedge clk);
    load_prog2();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_to_halt("R11 undefined opcode halts");
    chk("R1 registers cleared by reset", dw(30), 16'h0003);
    chk("R11 nothing after undefined opcode", dw(28), 16'h0000);
    chk("R11 still halted", 16'(halted), 16'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=running expected=halted");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule